// File: doc/BRIEF.md
# Timed Hold Trigger Sequencer

This block is the trigger engine of a logic-analyzer front end. It watches one sampled input channel, which is active low, and raises a single-cycle trigger pulse. The pulse can halt a processor or freeze a capture buffer. A sticky flag records that the trigger has fired.

There are two modes. In hold mode the engine walks two levels. In the armed level it keeps a duration timer cleared. When the channel goes low it moves to the timing level. There it counts cycles while the channel stays low. If the channel rises again, it drops back to the armed level without firing. If the count reaches the programmed limit, it fires. In edge mode the engine fires at once on a falling edge of the channel.

The limit is a count of clock cycles. It is loaded while the engine is disabled. After a firing, further activity on the channel is ignored until software re-arms the engine.

Top module: `hold_trigger`

## Requirements
- R1: While reset is asserted and right after it, `trigPulse` and `triggered` are 0.
- R2: In hold mode (`modeSel`=0) with loaded limit L, a low on `chanIn` lasting D consecutive cycles produces a trigger exactly when D >= L+2. A shorter low produces no pulse.
- R3: In hold mode, counting the first rising edge that samples `chanIn` low as edge 1, `trigPulse` is high after edge L+4. This covers two synchronizer flops, the level change and the output register.
- R4: A rise of `chanIn` during timing returns the engine to the armed level. A later low restarts the timer from zero.
- R5: In edge mode (`modeSel`=1), a falling edge of `chanIn` fires after edge 3, whatever the duration of the low.
- R6: `trigPulse` is high for exactly one cycle per firing.
- R7: `triggered` is set together with the pulse and stays set. While it is set, no further pulse is produced, whatever `chanIn` does.
- R8: A one-cycle `rearm` clears `triggered` on the next edge and returns the engine to the armed level, so a later event can fire again.
- R9: `timeoutIn` is captured only while `enable` is 0. Changing it while enabled does not alter the active limit.
- R10: While `enable` is 0 no pulse is produced, and the engine is held in the armed level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the sequencer. While low, the limit is loaded. |
| modeSel | input | 1 | 0: timed hold trigger, 1: falling-edge trigger |
| rearm | input | 1 | Synchronous clear of the fired state and flag |
| timeoutIn | input | CNT_W | Duration limit in clock cycles |
| chanIn | input | 1 | Monitored channel, event when low |
| trigPulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky fired flag |

## Verification
Hold mode is swept over limits 0 to 4. For each limit, every low duration from one cycle up to four cycles past the limit is tried. This separates lows one cycle too short from lows just long enough, and pins the exact firing edge.

A low with a one-cycle gap before a long low shows that the timer restarts rather than carrying over. Edge mode is driven with short and long lows, which shows that duration does not matter there.

Long lows after a firing, a limit change while enabled, and lows while disabled each test that an input has no effect. Each of these is checked at the pulse and flag outputs.

// File: rtl/hold_trigger_pkg.sv
package hold_trigger_pkg;

  typedef enum logic [1:0] {
    LVL_ARMED  = 2'd0,
    LVL_TIMING = 2'd1,
    LVL_FIRED  = 2'd2
  } level_e;

  typedef struct packed {
    logic restart;
    logic advance;
  } tmrCtl_t;

endpackage

// File: rtl/hold_trigger_dp.sv
module hold_trigger_dp
  import hold_trigger_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned DEF_LIMIT   = 10_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             chanIn,
  input  logic [CNT_W-1:0] timeoutIn,
  input  tmrCtl_t          ctl,
  output logic             eventNow,
  output logic             fallEdge,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LIM_INIT = CNT_W'(DEF_LIMIT);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSync;
  logic                   syncOut;
  logic [CNT_W-1:0]       limitReg;
  logic [CNT_W-1:0]       tmrCnt;

  // resynchronizer chain, idle level is high
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[s] <= 1'b1;
      end else if (s == 0) begin
        syncQ[s] <= chanIn;
      end else begin
        syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSync <= 1'b1;
    else       prevSync <= syncOut;
  end

  assign eventNow = ~syncOut;
  assign fallEdge = prevSync & ~syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        limitReg <= LIM_INIT;
    else if (!enable) limitReg <= timeoutIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (ctl.restart) begin
      tmrCnt <= '0;
    end else if (ctl.advance && (tmrCnt != CNT_MAX)) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  assign expired = (tmrCnt >= limitReg);

endmodule

// File: rtl/hold_trigger_ctl.sv
module hold_trigger_ctl
  import hold_trigger_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    modeSel,
  input  logic    rearm,
  input  logic    eventNow,
  input  logic    fallEdge,
  input  logic    expired,
  output tmrCtl_t ctl,
  output logic    trigPulse,
  output logic    triggered
);

  level_e lvl, nextLvl;
  logic   fire;

  always_comb begin
    nextLvl     = lvl;
    fire        = 1'b0;
    ctl.restart = 1'b1;
    ctl.advance = 1'b0;
    unique case (lvl)
      LVL_ARMED: begin
        if (enable) begin
          if (modeSel) begin
            fire = fallEdge;
          end else if (eventNow) begin
            nextLvl = LVL_TIMING;
          end
        end
      end
      LVL_TIMING: begin
        ctl.restart = 1'b0;
        ctl.advance = 1'b1;
        if (!enable || !eventNow) begin
          nextLvl = LVL_ARMED;
        end else if (expired) begin
          fire = 1'b1;
        end
      end
      default: begin
        nextLvl = LVL_FIRED;
      end
    endcase
    if (fire) nextLvl = LVL_FIRED;
    if (rearm) begin
      fire    = 1'b0;
      nextLvl = LVL_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl       <= LVL_ARMED;
      trigPulse <= 1'b0;
      triggered <= 1'b0;
    end else begin
      lvl       <= nextLvl;
      trigPulse <= fire;
      if (rearm)     triggered <= 1'b0;
      else if (fire) triggered <= 1'b1;
    end
  end

endmodule

// File: rtl/hold_trigger.sv
module hold_trigger
  import hold_trigger_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned DEF_LIMIT   = 10_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeSel,
  input  logic             rearm,
  input  logic [CNT_W-1:0] timeoutIn,
  input  logic             chanIn,
  output logic             trigPulse,
  output logic             triggered
);

  tmrCtl_t tmrCtl;
  logic    eventNow, fallEdge, expired;

  hold_trigger_dp #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .DEF_LIMIT  (DEF_LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .chanIn   (chanIn),
    .timeoutIn(timeoutIn),
    .ctl      (tmrCtl),
    .eventNow (eventNow),
    .fallEdge (fallEdge),
    .expired  (expired)
  );

  hold_trigger_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .modeSel  (modeSel),
    .rearm    (rearm),
    .eventNow (eventNow),
    .fallEdge (fallEdge),
    .expired  (expired),
    .ctl      (tmrCtl),
    .trigPulse(trigPulse),
    .triggered(triggered)
  );

endmodule

// File: rtl/hold_trigger_chk.sv
module hold_trigger_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic rearm,
  input logic trigPulse,
  input logic triggered
);

  // R1: outputs quiet during reset
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!trigPulse && !triggered);
    end
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  p_flag_with_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> triggered);

  p_no_refire_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(triggered) && !$past(rearm)) |-> !trigPulse);

  p_rearm_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> (!triggered && !trigPulse));

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !trigPulse);

endmodule

bind hold_trigger hold_trigger_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .rearm    (rearm),
  .trigPulse(trigPulse),
  .triggered(triggered)
);

// File: tb/hold_trigger_bench.sv
module hold_trigger_bench;

  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             modeSel = 1'b0;
  logic             rearm = 1'b0;
  logic [CNT_W-1:0] timeoutIn = '0;
  logic             chanIn = 1'b1;
  logic             trigPulse, triggered;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  hold_trigger #(.CNT_W(CNT_W)) u_hold_trigger (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .modeSel  (modeSel),
    .rearm    (rearm),
    .timeoutIn(timeoutIn),
    .chanIn   (chanIn),
    .trigPulse(trigPulse),
    .triggered(triggered)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRearm();
    rearm = 1'b1;
    cycle();
    rearm = 1'b0;
    repeat (4) cycle();
  endtask

  // load a mode and limit while disabled, then run armed
  task automatic cfg(input logic mode, input int lim);
    enable    = 1'b0;
    modeSel   = mode;
    timeoutIn = CNT_W'(lim);
    chanIn    = 1'b1;
    repeat (2) cycle();
    enable = 1'b1;
    doRearm();
  endtask

  // drive chanIn low for lowLen cycles; report first pulse edge index and pulse count
  task automatic trial(input int lowLen, input int horizon,
                       output int hitIdx, output int hits);
    hitIdx = 0;
    hits   = 0;
    chanIn = 1'b0;
    for (int i = 1; i <= horizon; i++) begin
      cycle();
      if (trigPulse) begin
        hits++;
        if (hitIdx == 0) hitIdx = i;
      end
      if (i == lowLen) chanIn = 1'b1;
    end
    chanIn = 1'b1;
    repeat (3) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    int idx, hits;
    @(negedge clk);
    chk("R1 pulse in reset", trigPulse, 0);
    chk("R1 flag in reset", triggered, 0);
    repeat (2) cycle();
    rstN = 1'b1;
    cycle();
    chk("R1 pulse after reset", trigPulse, 0);
    chk("R1 flag after reset", triggered, 0);

    // R2 R3 R6: sweep limits and low durations in hold mode
    for (int lim = 0; lim <= 4; lim++) begin
      cfg(1'b0, lim);
      for (int d = 1; d <= lim + 4; d++) begin
        int expFire;
        expFire = (d >= lim + 2) ? 1 : 0;
        trial(d, lim + 8, idx, hits);
        chk($sformatf("R2 fire L=%0d D=%0d", lim, d), hits, expFire);
        chk("R7 flag follows fire", triggered, expFire);
        if (expFire == 1) begin
          chk($sformatf("R3 edge L=%0d D=%0d", lim, d), idx, lim + 4);
        end
        doRearm();
        chk("R8 flag cleared", triggered, 0);
      end
    end

    // R4: one-cycle gap restarts the timer, L=3
    cfg(1'b0, 3);
    idx = 0;
    hits = 0;
    chanIn = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      cycle();
      if (trigPulse) begin
        hits++;
        if (idx == 0) idx = i;
      end
      chanIn = (i == 4) ? 1'b1 : 1'b0;
    end
    chanIn = 1'b1;
    repeat (3) cycle();
    chk("R4 restart pulse count", hits, 1);
    chk("R4 restart edge", idx, 12);
    doRearm();

    // R5: edge mode, short and long lows, big limit irrelevant
    cfg(1'b1, 50);
    for (int d = 1; d <= 6; d += 5) begin
      trial(d, 10, idx, hits);
      chk($sformatf("R5 edge count D=%0d", d), hits, 1);
      chk($sformatf("R5 edge index D=%0d", d), idx, 3);
      doRearm();
    end

    // R6 R7: long low fires once, later lows ignored while flag set
    cfg(1'b0, 1);
    trial(20, 30, idx, hits);
    chk("R6 single pulse", hits, 1);
    chk("R3 edge L=1 long", idx, 5);
    trial(10, 15, idx, hits);
    chk("R7 ignored after fire", hits, 0);
    chk("R7 flag sticky", triggered, 1);
    doRearm();
    chk("R8 rearm clears", triggered, 0);
    trial(10, 15, idx, hits);
    chk("R8 fires again after rearm", hits, 1);
    doRearm();

    // R9: limit change while enabled has no effect
    cfg(1'b0, 2);
    timeoutIn = CNT_W'(20);
    cycle();
    trial(10, 14, idx, hits);
    chk("R9 edge with old limit", idx, 6);
    doRearm();

    // R10: disabled engine never fires, in either mode
    cfg(1'b0, 1);
    enable = 1'b0;
    trial(10, 15, idx, hits);
    chk("R10 hold mode disabled", hits, 0);
    chk("R10 flag disabled", triggered, 0);
    modeSel = 1'b1;
    trial(3, 8, idx, hits);
    chk("R10 edge mode disabled", hits, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule